// File: doc/BRIEF.md
# Power-up Sequencer with Strap Capture

This block brings a receiver-style device out of reset and into operation. An asynchronous active-low reset is synchronized to the clock. While reset is held, every register in the block sits at its default value. The device reports low-power mode, the outputs are muted, and the two strap-capable pads are inputs. Shortly after reset is released, the block samples the pad levels once and then turns the pads around to outputs. One strap, taken from the serial-data pad, chooses hardware or software mode. The other, taken from a general-purpose pad, supplies one address bit for the I2C control port.

In software mode the control port opens as soon as the straps are latched. The device stays in low power until software writes 1 to the RUN bit. In hardware mode RUN plays no part, and the device moves straight on to waiting for the PLL. In both modes the outputs are released only after the PLL lock indication has stayed high for a programmable number of consecutive cycles. They are muted again in the same cycle that lock drops. Clearing RUN sends the device back to low power.

A small register window holds the RUN control bit and a read-only byte made of a 4-bit device ID and a 4-bit revision code.

Top module: `pwrup_seq`

## Requirements
- R1: While rst_n is low: low_power_o=1, mute_o=1, ctrl_en_o=0, strap_oe_o=2'b00, mode_sw_o=0, and RUN is cleared.
- R2: After rst_n rises, two synchronizer stages pass before the straps are latched, on the third rising edge. strap_oe_o becomes 2'b11 on the fourth edge and stays 2'b11 until the next reset. Pad changes after the capture edge have no effect on mode_sw_o or addr_bit_o.
- R3: Strap bit 0 (serial-data pad) latched as 1 selects software mode (mode_sw_o=1). Latched as 0, it selects hardware mode (mode_sw_o=0).
- R4: addr_bit_o equals the latched strap bit 1 (general-purpose pad) in software mode, and is 0 in hardware mode.
- R5: ctrl_en_o is 1 from the capture edge onward in software mode only. A write with reg_addr_i=0 loads RUN from reg_wdata_i bit 0, and only while ctrl_en_o is 1.
- R6: In software mode low_power_o stays 1 after capture until RUN is 1. It falls on the first edge at which RUN is already 1.
- R7: After leaving low power, mute_o stays 1 until pll_lock_i has been sampled high on LOCK_CYCLES consecutive edges. It falls on the edge of the last of them. A low sample restarts the count.
- R8: In the cycle pll_lock_i falls, mute_o rises without waiting for a clock edge, and the full lock qualification of R7 applies again.
- R9: Writing RUN=0 in software mode sets mute_o at once and returns low_power_o to 1 on the next edge. The ID/revision byte is unchanged.
- R10: In hardware mode, low_power_o falls on the same edge that sets strap_oe_o. Writes are ignored, so RUN reads 0.
- R11: Reading reg_addr_i=1 returns {ID_CODE, REV_CODE} (ID in bits 7:4), and writes there change nothing. reg_addr_i=0 reads RUN in bit 0 with the other bits 0. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| pll_lock_i | input | 1 | PLL lock indication |
| strap_pad_i | input | 2 | Pad levels: bit 0 serial-data pad, bit 1 general-purpose pad |
| strap_oe_o | output | 2 | Output enable for the two strap pads |
| mode_sw_o | output | 1 | 1 = software mode, 0 = hardware mode |
| addr_bit_o | output | 1 | Control-port address bit |
| low_power_o | output | 1 | Device in low-power state |
| ctrl_en_o | output | 1 | Control port usable |
| mute_o | output | 1 | Serial audio outputs muted |

## Verification
The bound checker watches, on every cycle, the invariants that relate the outputs to each other. In reset the device is quiet. Once the pads are driven, the latched mode does not move, and the pads never drop back to inputs. The outputs are unmuted only with lock high, the device awake, and RUN set in software mode. Low power ends in software mode only after RUN has been seen. The exact edge counts can only be shown by the bench's scenarios, with its reference model compared on every clock. These include the synchronizer and capture delay, the length of the lock qualification and its restart after a short lock burst, and the exact cycle of the turnaround and the wake-up.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_DRIVE  = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_LOCKW  = 3'd3,
    ST_ACTIVE = 3'd4
  } pwr_state_e;

  localparam int STRAP_N    = 2;
  localparam int STRAP_MODE = 0;
  localparam int STRAP_ADDR = 1;

  localparam int REG_CTRL = 0;
  localparam int REG_IDRV = 1;
  localparam int DATA_W   = 8;

endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwrup_strap_latch.sv
module pwrup_strap_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         drv_en,
  input  logic [N-1:0] pad_i,
  output logic [N-1:0] val_o,
  output logic [N-1:0] oe_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic val_q, val_d, oe_q, oe_d;

    always_comb begin
      val_d = val_q;
      oe_d  = oe_q;
      if (cap_en) val_d = pad_i[i];
      if (drv_en) oe_d  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= 1'b0;
        oe_q  <= 1'b0;
      end else begin
        val_q <= val_d;
        oe_q  <= oe_d;
      end
    end

    assign val_o[i] = val_q;
    assign oe_o[i]  = oe_q;
  end
endmodule

// File: rtl/pwrup_lock_timer.sv
module pwrup_lock_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic lock_i,
  output logic done_o
);
  localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [W-1:0] LAST = W'(CYCLES - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign done_o = count_en && lock_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!count_en || !lock_i || done_o) cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwrup_regs.sv
module pwrup_regs
  import pwrup_pkg::*;
#(
  parameter int         ADDR_W   = 2,
  parameter logic [3:0] ID_CODE  = 4'h9,
  parameter logic [3:0] REV_CODE = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o
);
  logic run_q, run_d;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:1];

  always_comb begin
    run_d = run_q;
    if (wr_ok && wr_i && (addr_i == ADDR_W'(REG_CTRL))) run_d = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  always_comb begin
    if (addr_i == ADDR_W'(REG_CTRL))      rdata_o = {{(DATA_W-1){1'b0}}, run_q};
    else if (addr_i == ADDR_W'(REG_IDRV)) rdata_o = {ID_CODE, REV_CODE};
    else                                  rdata_o = '0;
  end

  assign run_o = run_q;
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int         LOCK_CYCLES = 1024,
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 2,
  parameter logic [3:0] ID_CODE     = 4'h9,
  parameter logic [3:0] REV_CODE    = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              pll_lock_i,
  input  logic [1:0]        strap_pad_i,
  output logic [1:0]        strap_oe_o,
  output logic              mode_sw_o,
  output logic              addr_bit_o,
  output logic              low_power_o,
  output logic              ctrl_en_o,
  output logic              mute_o
);
  logic             rst_core_n;
  pwr_state_e       state_q, state_d;
  logic [STRAP_N-1:0] strap_val;
  logic             lock_done;
  logic             run_q;
  logic             sw_mode;

  pwrup_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  pwrup_strap_latch #(.N(STRAP_N)) u_strap (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .cap_en (state_q == ST_HOLD),
    .drv_en (state_q == ST_DRIVE),
    .pad_i  (strap_pad_i),
    .val_o  (strap_val),
    .oe_o   (strap_oe_o)
  );

  assign sw_mode = strap_val[STRAP_MODE];

  pwrup_lock_timer #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .count_en (state_q == ST_LOCKW),
    .lock_i   (pll_lock_i),
    .done_o   (lock_done)
  );

  pwrup_regs #(
    .ADDR_W   (ADDR_W),
    .ID_CODE  (ID_CODE),
    .REV_CODE (REV_CODE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_ok   (ctrl_en_o),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .run_o   (run_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD:   state_d = ST_DRIVE;
      ST_DRIVE:  state_d = sw_mode ? ST_SLEEP : ST_LOCKW;
      ST_SLEEP:  if (run_q) state_d = ST_LOCKW;
      ST_LOCKW: begin
        if (sw_mode && !run_q) state_d = ST_SLEEP;
        else if (lock_done)    state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (sw_mode && !run_q) state_d = ST_SLEEP;
        else if (!pll_lock_i)  state_d = ST_LOCKW;
      end
      default:   state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_HOLD;
    else             state_q <= state_d;
  end

  assign mode_sw_o   = sw_mode;
  assign addr_bit_o  = sw_mode & strap_val[STRAP_ADDR];
  assign ctrl_en_o   = sw_mode && (state_q != ST_HOLD);
  assign low_power_o = (state_q == ST_HOLD) || (state_q == ST_DRIVE) ||
                       (state_q == ST_SLEEP);
  assign mute_o      = !((state_q == ST_ACTIVE) && pll_lock_i &&
                         (!sw_mode || run_q));
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_lock_i,
  input logic [1:0] strap_oe_o,
  input logic       mode_sw_o,
  input logic       addr_bit_o,
  input logic       low_power_o,
  input logic       ctrl_en_o,
  input logic       mute_o,
  input logic       run_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (low_power_o && mute_o && !ctrl_en_o && strap_oe_o == 2'b00));

  // R2
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_oe_o != 2'b00) |=> (strap_oe_o == 2'b11));

  // R2
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_oe_o != 2'b00) |=> ($stable(mode_sw_o) && $stable(addr_bit_o)));

  // R5
  ctrl_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en_o |-> mode_sw_o);

  // R6
  wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(low_power_o) && mode_sw_o) |-> $past(run_q));

  // R7
  unmute_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_o |-> (pll_lock_i && !low_power_o && strap_oe_o == 2'b11));

  // R9
  unmute_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_o && mode_sw_o) |-> run_q);

  // R10
  hw_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sw_o |-> (!ctrl_en_o && !addr_bit_o));
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pll_lock_i  (pll_lock_i),
  .strap_oe_o  (strap_oe_o),
  .mode_sw_o   (mode_sw_o),
  .addr_bit_o  (addr_bit_o),
  .low_power_o (low_power_o),
  .ctrl_en_o   (ctrl_en_o),
  .mute_o      (mute_o),
  .run_q       (run_q)
);

// File: tb/tb_pwrup_seq.sv
`timescale 1ns/1ps
module tb_pwrup_seq;
  localparam int N = 8;
  localparam logic [3:0] IDC = 4'h6;
  localparam logic [3:0] RVC = 4'h1;

  logic       clk;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       pll_lock;
  logic [1:0] pads;
  logic [1:0] strap_oe;
  logic       mode_sw, addr_bit, low_power, ctrl_en, mute;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pwrup_seq #(.LOCK_CYCLES(N), .ID_CODE(IDC), .REV_CODE(RVC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .pll_lock_i(pll_lock),
    .strap_pad_i(pads), .strap_oe_o(strap_oe), .mode_sw_o(mode_sw),
    .addr_bit_o(addr_bit), .low_power_o(low_power), .ctrl_en_o(ctrl_en),
    .mute_o(mute)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 wait, 1 turnaround, 2 asleep, 3 lock wait, 4 running
  int m_s0 = 0, m_s1 = 0, m_ph = 0, m_cnt = 0, m_run = 0, m_mode = 0, m_addr = 0, m_oe = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_ph = 0; m_cnt = 0; m_run = 0; m_mode = 0; m_addr = 0; m_oe = 0;
    end else begin
      int nrun;
      nrun = m_run;
      if (m_ph != 0 && m_mode == 1 && reg_wr && reg_addr == 2'd0) nrun = reg_wdata[0];
      case (m_ph)
        0: if (m_s1 == 1) begin m_mode = pads[0]; m_addr = pads[1]; m_ph = 1; end
        1: begin m_oe = 3; m_cnt = 0; m_ph = (m_mode == 1) ? 2 : 3; end
        2: if (m_run == 1) begin m_ph = 3; m_cnt = 0; end
        3: begin
          if (m_mode == 1 && m_run == 0) m_ph = 2;
          else if (pll_lock) begin
            if (m_cnt == N - 1) begin m_ph = 4; m_cnt = 0; end
            else m_cnt++;
          end else m_cnt = 0;
        end
        default: begin
          if (m_mode == 1 && m_run == 0) m_ph = 2;
          else if (!pll_lock) begin m_ph = 3; m_cnt = 0; end
        end
      endcase
      m_s1 = m_s0;
      m_s0 = 1;
      m_run = nrun;
    end
  end

  always @(negedge clk) begin
    int exp_rd;
    if (reg_addr == 2'd0) exp_rd = m_run;
    else if (reg_addr == 2'd1) exp_rd = {IDC, RVC};
    else exp_rd = 0;
    chk("R7", "mute", mute, (m_ph == 4 && pll_lock && (m_mode == 0 || m_run == 1)) ? 0 : 1);
    chk("R6", "low_power", low_power, (m_ph <= 2) ? 1 : 0);
    chk("R5", "ctrl_en", ctrl_en, (m_ph != 0 && m_mode == 1) ? 1 : 0);
    chk("R2", "strap_oe", strap_oe, m_oe);
    chk("R3", "mode_sw", mode_sw, m_mode);
    chk("R4", "addr_bit", addr_bit, m_mode & m_addr);
    chk("R11", "rdata", reg_rdata, exp_rd);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); #2;
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic reg_read(input logic [1:0] a, output int v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic boot(input logic [1:0] p);
    @(negedge clk); #2;
    rst_n = 1'b0; pads = p;
    step(3);
    chk("R1", "reset low_power", low_power, 1);
    chk("R1", "reset mute", mute, 1);
    chk("R1", "reset ctrl_en", ctrl_en, 0);
    chk("R1", "reset strap_oe", strap_oe, 0);
    #2 rst_n = 1'b1;
    step(2);
    chk("R2", "mode before capture", mode_sw, 0);
    step(1);
    chk("R2", "mode at capture", mode_sw, p[0]);
    chk("R2", "oe at capture", strap_oe, 0);
    step(1);
    chk("R2", "oe after turnaround", strap_oe, 3);
    #2 pads = ~p;
  endtask

  initial begin
    int v;
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    pll_lock = 1'b0; pads = 2'b11;

    // Software mode, address strap 1
    boot(2'b11);
    step(2);
    chk("R2", "mode kept after pad change", mode_sw, 1);
    chk("R4", "addr bit", addr_bit, 1);
    reg_write(2'd1, 8'hFF);
    reg_read(2'd1, v);
    chk("R11", "id/rev after write", v, {IDC, RVC});
    reg_read(2'd2, v);
    chk("R11", "unused address", v, 0);
    reg_read(2'd0, v);
    chk("R11", "run before write", v, 0);
    step(4);
    chk("R6", "asleep without run", low_power, 1);
    reg_write(2'd0, 8'h01);
    chk("R6", "still asleep at run edge", low_power, 1);
    step(1);
    chk("R6", "awake after run", low_power, 0);
    step(3);
    chk("R7", "muted without lock", mute, 1);
    #2 pll_lock = 1'b1;
    step(N - 1);
    chk("R7", "muted one short", mute, 1);
    #2 pll_lock = 1'b0;
    step(2);
    #2 pll_lock = 1'b1;
    step(N - 1);
    chk("R7", "restart after short burst", mute, 1);
    step(1);
    chk("R7", "unmuted after full count", mute, 0);
    step(3);
    #2 pll_lock = 1'b0;
    #1 chk("R8", "immediate mute on lock loss", mute, 1);
    step(1);
    #2 pll_lock = 1'b1;
    step(N - 1);
    chk("R8", "requalify after loss", mute, 1);
    step(1);
    chk("R8", "unmuted after requalify", mute, 0);
    step(2);
    reg_write(2'd0, 8'h00);
    chk("R9", "mute on run clear", mute, 1);
    chk("R9", "still awake at clear edge", low_power, 0);
    step(1);
    chk("R9", "back to low power", low_power, 1);
    reg_read(2'd1, v);
    chk("R9", "id/rev kept", v, {IDC, RVC});
    step(4);

    // Hardware mode, address strap 1 presented but ignored
    pll_lock = 1'b1;
    boot(2'b10);
    chk("R10", "hw awake at turnaround", low_power, 0);
    chk("R10", "hw control closed", ctrl_en, 0);
    chk("R4", "hw addr bit", addr_bit, 0);
    chk("R3", "hw mode", mode_sw, 0);
    reg_write(2'd0, 8'h01);
    reg_read(2'd0, v);
    chk("R10", "hw run ignored", v, 0);
    step(N);
    chk("R10", "hw unmuted without run", mute, 0);
    step(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule